// File: doc/BRIEF.md
# Clause 22 Management Bus Master

This block lets a host reach the registers of an Ethernet PHY over the two-wire clause 22 management interface. The host sees nine byte-wide registers. Four command bytes hold the write data, the PHY address, the register address and the direction. Two status bytes return the data from a read, and a third carries a failure flag. One core-control byte gates the management clock. Setting the start bit in the top command byte launches one 64-bit serial frame on MDC/MDIO. The start bit stays set until the frame has been shifted out.

MDC is derived from the system clock. Each half period lasts `HALF_DIV` clocks, so the default of 20 at 100 MHz gives 2.5 MHz. The block changes MDIO only on falling MDC edges and samples the PHY on rising edges. During a read it releases the line from the turnaround onward. If the PHY fails to pull the second turnaround bit low, the read is marked as failed.

Host address map: 0 to 3 are the command bytes, 4 to 7 the status bytes, and 8 the core-control byte. Every other address reads as zero.

Top module: `mdio_master`

## Requirements
- R1: Command byte 0 holds write data bits 7:0 and byte 1 holds bits 15:8. Byte 2 holds the register address in bits 4:0 and PHY address bits 2:0 in bits 7:5. Byte 3 holds PHY address bits 4:3 in bits 1:0 and the write flag in bit 2 (1 = write, 0 = read). All of these read back as written.
- R2: Writing byte 3 with bit 7 set while idle starts a frame. Bit 7 of byte 3 reads 1 from the clock after that write until the frame ends, which is 128*HALF_DIV clocks later.
- R3: Host writes to command bytes 0 to 3 are ignored while a frame is in progress.
- R4: A frame sends, MSB first: 32 ones, then start 01, then opcode 01 for a write or 10 for a read, then the 5-bit PHY address, then the 5-bit register address. A write follows with turnaround 10 and the 16 data bits.
- R5: On a read, MDIO output enable is high from the preamble through the register address. It drops for the two turnaround bits and the 16 data bits. While idle, the enable is low.
- R6: After a read, status byte 0 holds the 16 sampled data bits 7:0 and status byte 1 holds bits 15:8. A write frame leaves both status bytes unchanged.
- R7: Status byte 3 bit 7 is set when MDIO is sampled high on the second turnaround bit of a read. It stays set until the next frame starts. Status byte 2 and the other bits of status byte 3 read 0.
- R8: While a frame runs, MDC toggles every HALF_DIV clocks, starting low, and MDIO output changes only together with a falling MDC edge. While idle, MDC is low and MDIO output is 1.
- R9: Core-control bit 4 enables the management clock and resets to 1. While it is 0, MDC does not toggle and a running frame pauses. The frame resumes when the bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |
| mdio_in | input | 1 | Sampled MDIO line |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
A wrong bit index or divider count in this block shows up within one MDC half period as a mismatch on mdc, mdio_oe or mdio_out. A corrupted busy state shows up in the readback of command byte 3 in the same clock. Sampling faults appear only at the end of a read, in status bytes 0, 1 and 3. Each read therefore uses a PHY response pattern with distinct bytes, and includes a case where the turnaround acknowledgement is missing.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_DIV = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       mdio_in,
  output logic       mdc,
  output logic       mdio_out,
  output logic       mdio_oe
);
  localparam int FRAME_LEN = 64;
  localparam int TA_IDX    = 46;
  localparam int DATA_IDX  = 48;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int DIV_W     = $clog2(HALF_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [7:0] cmd_d0, cmd_d1, cmd_a;
  logic [1:0] pa_hi;
  logic       wr_flag, busy, is_rd, fail, mdc_en;
  logic [7:0] st_lo, st_hi;
  logic [DIV_W-1:0] div_cnt;
  logic [FRAME_LEN-1:0] sr;
  logic [IDX_W-1:0] idx;
  logic [15:0] rd_sh;

  logic        tick, rise, fall, start, new_wr;
  logic [4:0]  new_phy;
  logic [63:0] new_frame;

  assign tick  = busy && mdc_en && (div_cnt == DIV_LAST);
  assign rise  = tick && !mdc;
  assign fall  = tick && mdc;
  assign start = host_we && !busy && (host_addr == 4'd3) && host_wdata[7];

  assign new_wr    = host_wdata[2];
  assign new_phy   = {host_wdata[1:0], cmd_a[7:5]};
  assign new_frame = {32'hFFFF_FFFF, 2'b01, new_wr ? 2'b01 : 2'b10, new_phy, cmd_a[4:0],
                      new_wr ? 2'b10 : 2'b11, new_wr ? {cmd_d1, cmd_d0} : 16'hFFFF};

  assign mdio_out = busy ? sr[FRAME_LEN-1] : 1'b1;
  assign mdio_oe  = busy && !(is_rd && (idx >= IDX_W'(TA_IDX)));

  always_comb begin
    case (host_addr)
      4'd0:    host_rdata = cmd_d0;
      4'd1:    host_rdata = cmd_d1;
      4'd2:    host_rdata = cmd_a;
      4'd3:    host_rdata = {busy, 4'b0000, wr_flag, pa_hi};
      4'd4:    host_rdata = st_lo;
      4'd5:    host_rdata = st_hi;
      4'd7:    host_rdata = {fail, 7'b0};
      4'd8:    host_rdata = {3'b000, mdc_en, 4'b0000};
      default: host_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_d0  <= '0;
      cmd_d1  <= '0;
      cmd_a   <= '0;
      pa_hi   <= '0;
      wr_flag <= 1'b0;
      busy    <= 1'b0;
      is_rd   <= 1'b0;
      fail    <= 1'b0;
      mdc_en  <= 1'b1;
      st_lo   <= '0;
      st_hi   <= '0;
      div_cnt <= '0;
      mdc     <= 1'b0;
      sr      <= '0;
      idx     <= '0;
      rd_sh   <= '0;
    end else begin
      if (host_we && host_addr == 4'd8)
        mdc_en <= host_wdata[4];
      if (host_we && !busy) begin
        case (host_addr)
          4'd0: cmd_d0 <= host_wdata;
          4'd1: cmd_d1 <= host_wdata;
          4'd2: cmd_a  <= host_wdata;
          4'd3: begin
            pa_hi   <= host_wdata[1:0];
            wr_flag <= host_wdata[2];
          end
          default: ;
        endcase
      end
      if (start) begin
        busy    <= 1'b1;
        is_rd   <= !new_wr;
        fail    <= 1'b0;
        sr      <= new_frame;
        idx     <= '0;
        div_cnt <= '0;
        mdc     <= 1'b0;
      end else if (busy && mdc_en) begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick)
          mdc <= !mdc;
        if (rise && is_rd) begin
          if (idx == IDX_W'(TA_IDX + 1) && mdio_in)
            fail <= 1'b1;
          if (idx >= IDX_W'(DATA_IDX))
            rd_sh <= {rd_sh[14:0], mdio_in};
        end
        if (fall) begin
          if (idx == IDX_W'(FRAME_LEN - 1)) begin
            busy <= 1'b0;
            if (is_rd) begin
              st_lo <= rd_sh[7:0];
              st_hi <= rd_sh[15:8];
            end
          end else begin
            idx <= idx + 1'b1;
            sr  <= {sr[FRAME_LEN-2:0], 1'b0};
          end
        end
      end
    end
  end

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdc); // R8
  AST_MDC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (busy && !mdc_en) |=> $stable(mdc)); // R9
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> ($stable(cmd_d0) && $stable(cmd_a))); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (!busy || idx == $past(idx) || idx == $past(idx) + 1'b1)); // R2
  AST_END_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(idx) == IDX_W'(FRAME_LEN - 1)); // R2
  AST_NO_FAIL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (busy && !is_rd) |-> !fail); // R7
  AST_OUT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy) && !$stable(mdio_out)) |-> $fell(mdc)); // R8
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int HALF_DIV = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [3:0] host_addr = 4'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       mdio_in = 1'b1;
  logic       mdc, mdio_out, mdio_oe;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF_DIV)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdio_in(mdio_in),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  // reference model state
  bit [7:0] m_c0, m_c1, m_c2, m_c3;
  bit m_busy, m_rd, m_mdc, m_en, m_fail;
  int m_idx, m_cnt;
  bit [15:0] m_sh, m_st;
  bit [15:0] resp = 16'h0000;
  bit ack_bad = 1'b0;
  int toggles = 0;

  function automatic bit fbit(int i);
    bit [4:0] phy, rg;
    bit wr;
    phy = {m_c3[1:0], m_c2[7:5]};
    rg  = m_c2[4:0];
    wr  = !m_rd;
    if (i < 32) return 1'b1;
    if (i == 32) return 1'b0;
    if (i == 33) return 1'b1;
    if (i == 34) return wr ? 1'b0 : 1'b1;
    if (i == 35) return wr ? 1'b1 : 1'b0;
    if (i <= 40) return phy[40 - i];
    if (i <= 45) return rg[45 - i];
    if (i == 46) return 1'b1;
    if (i == 47) return !wr;
    return wr ? m_c1_c0(63 - i) : 1'b1;
  endfunction

  function automatic bit m_c1_c0(int b);
    bit [15:0] d;
    d = {m_c1, m_c0};
    return d[b];
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit ob, oe;
    #1;
    if (!rst_n) begin
      m_busy = 0; m_rd = 0; m_mdc = 0; m_en = 1; m_fail = 0;
      m_idx = 0; m_cnt = 0; m_sh = 0; m_st = 0;
      m_c0 = 0; m_c1 = 0; m_c2 = 0; m_c3 = 0;
    end else begin
      ob = m_busy; oe = m_en;
      if (ob && oe) begin
        m_cnt++;
        if (m_cnt == HALF_DIV) begin
          m_cnt = 0;
          toggles++;
          if (!m_mdc) begin
            m_mdc = 1;
            if (m_rd && m_idx == 47 && mdio_in) m_fail = 1;
            if (m_rd && m_idx >= 48) m_sh = {m_sh[14:0], mdio_in};
          end else begin
            m_mdc = 0;
            if (m_idx == 63) begin
              m_busy = 0;
              if (m_rd) m_st = m_sh;
            end else m_idx++;
          end
        end
      end
      if (host_we && !ob) begin
        case (host_addr)
          4'd0: m_c0 = host_wdata;
          4'd1: m_c1 = host_wdata;
          4'd2: m_c2 = host_wdata;
          4'd3: begin
            m_c3 = {1'b0, 4'b0, host_wdata[2:0]};
            if (host_wdata[7]) begin
              m_busy = 1; m_idx = 0; m_fail = 0; m_rd = !host_wdata[2];
              m_cnt = 0; m_mdc = 0;
            end
          end
          default: ;
        endcase
      end
      if (host_we && host_addr == 4'd8) m_en = host_wdata[4];
    end
    // PHY response for the next rising edge
    if (m_busy && m_rd && m_idx == 47) mdio_in = ack_bad;
    else if (m_busy && m_rd && m_idx >= 48) mdio_in = resp[63 - m_idx];
    else mdio_in = 1'b1;
    // per-cycle comparison: R8 clock, R5 enable, R4 frame bits, R2 busy readback
    chk("R8 mdc", mdc, m_mdc);
    chk("R5 mdio_oe", mdio_oe, m_busy && !(m_rd && m_idx >= 46));
    if (m_busy && !(m_rd && m_idx >= 46)) chk("R4 mdio_out", mdio_out, fbit(m_idx));
    if (!m_busy) chk("R8 idle out", mdio_out, 1);
    if (host_addr == 4'd3) chk("R2 go readback", host_rdata[7], m_busy);
  end

  task automatic wrreg(input bit [3:0] a, input bit [7:0] d);
    @(posedge clk); #2;
    host_we = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #2;
    host_we = 0;
  endtask

  task automatic rdreg(input bit [3:0] a, input bit [7:0] exp, input string req);
    @(posedge clk); #2;
    host_we = 0; host_addr = a;
    #1 chk(req, host_rdata, exp);
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    @(posedge clk); #2 host_addr = 4'd3;
    forever begin
      @(posedge clk); #3;
      cyc++;
      if (!host_rdata[7] || cyc > 20000) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    int t0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    // reset state
    rdreg(0, 8'h00, "R1 reset c0");
    rdreg(3, 8'h00, "R2 reset c3");
    rdreg(4, 8'h00, "R6 reset st0");
    rdreg(7, 8'h00, "R7 reset st3");
    rdreg(8, 8'h10, "R9 reset core");
    chk("R8 reset mdc", mdc, 0);

    // write frame: phy 0x13, reg 0x0A, data 0xA55A
    wrreg(0, 8'h5A); wrreg(1, 8'hA5); wrreg(2, 8'h6A);
    rdreg(2, 8'h6A, "R1 c2 readback");
    wrreg(3, 8'h86);
    rdreg(3, 8'h86, "R1 R2 c3 busy");
    wrreg(0, 8'hFF);
    wrreg(3, 8'h00);
    rdreg(0, 8'h5A, "R3 c0 held");
    rdreg(3, 8'h86, "R3 c3 held");
    wait_idle(cyc);
    chk("R2 completes in time", int'(cyc <= 128 * HALF_DIV), 1);
    rdreg(3, 8'h06, "R2 go cleared");
    rdreg(4, 8'h00, "R6 write keeps st0");
    rdreg(5, 8'h00, "R6 write keeps st1");

    // read with acknowledge
    resp = 16'hC3E1; ack_bad = 0;
    wrreg(2, 8'h25); wrreg(3, 8'h81);
    wait_idle(cyc);
    rdreg(4, 8'hE1, "R6 read st0");
    rdreg(5, 8'hC3, "R6 read st1");
    rdreg(7, 8'h00, "R7 ack ok");

    // read without acknowledge
    resp = 16'h1234; ack_bad = 1;
    wrreg(3, 8'h80);
    wait_idle(cyc);
    rdreg(7, 8'h80, "R7 fail set");
    rdreg(6, 8'h00, "R7 st2 zero");
    rdreg(4, 8'h34, "R6 st0 second read");

    // write clears the failure at start; status data retained
    ack_bad = 0;
    wrreg(3, 8'h84);
    rdreg(7, 8'h00, "R7 cleared at go");
    wait_idle(cyc);
    rdreg(4, 8'h34, "R6 write keeps st0");
    rdreg(5, 8'h12, "R6 write keeps st1");

    // clock disable pauses a read
    resp = 16'h0F5A;
    wrreg(8, 8'h00);
    rdreg(8, 8'h00, "R9 core cleared");
    wrreg(3, 8'h80);
    t0 = toggles;
    repeat (300) @(posedge clk);
    #3 chk("R9 no toggles", toggles - t0, 0);
    rdreg(3, 8'h80, "R9 still busy");
    wrreg(8, 8'h10);
    wait_idle(cyc);
    rdreg(4, 8'h5A, "R9 resumed st0");
    rdreg(5, 8'h0F, "R9 resumed st1");

    repeat (5) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule